// File: doc/BRIEF.md
# GPIO Interrupt Trigger Unit

This block watches a bank of general-purpose input pins and turns activity on them into interrupt requests. Each pin is brought into the local clock domain through a two-stage synchronizer. An optional per-pin inversion is applied next. The result is then judged against that pin's trigger setting, which can be rising edge, falling edge, both edges, high level or low level. Edge hits are held in a sticky pending bit until software clears them by writing a one. Level hits count as pending only while the level lasts.

Software uses a single-cycle write port to program the trigger codes, inversion bits, mask bits and output mode, and to clear pending bits. The pending vector is always visible on an output port. A masked pin still records pending status, but it takes no part in the interrupt lines. In shared mode, one line reports every unmasked pending pin. In split mode, the lower half of the bank drives one line and the upper half drives the other.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, every trigger code is 0, every polarity bit is 0, every mask bit is 1, the output mode is shared, no pin is pending, and both interrupt lines are low.
- R2: Trigger code 1 sets a pin's pending bit on a low-to-high change of the evaluated input. The bit stays set after the input returns low.
- R3: Trigger code 2 sets a pin's pending bit on a high-to-low change of the evaluated input, and the bit is sticky.
- R4: Trigger code 3 sets a pin's pending bit on a change in either direction, and the bit is sticky.
- R5: Trigger code 4 makes a pin pending exactly while its evaluated input is high. The pending bit drops with the level and needs no clear write.
- R6: Trigger code 8 makes a pin pending exactly while its evaluated input is low.
- R7: All other codes (0, 5, 6, 7 and 9 to 15) never make a pin pending.
- R8: Writing to address 2 clears the sticky pending bit of every pin whose data bit is 1, and leaves the pins whose data bit is 0 unchanged. If an edge event is detected in the same cycle as the clear write, the pending bit stays set.
- R9: The polarity register at address 1 holds one bit per pin, where 1 inverts that pin before trigger evaluation. A polarity change that flips the evaluated input counts as an edge.
- R10: The mask register at address 0 holds one bit per pin, where 1 blocks that pin from the interrupt lines. Masked pins still show pending status on `pend_o`.
- R11: Bit 0 of address 3 selects the output mode. With 0 (shared), `irq_lo_o` is the OR of all unmasked pending pins and `irq_hi_o` is low. With 1 (split), `irq_lo_o` serves pins 0 to 15 and `irq_hi_o` serves pins 16 to 31.
- R12: Trigger codes are written as 4-bit fields, eight pins per word. Address 8+n holds pins 8n to 8n+7, with pin p in bits 4*(p%8)+3 to 4*(p%8).
- R13: Count a pin change as seen by clock edge k. A level-triggered pending bit then appears after edge k+1, and an edge-triggered pending bit appears after edge k+2, not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pins_i | input | 32 | Asynchronous pin inputs |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| pend_o | output | 32 | Pending status per pin |
| irq_lo_o | output | 1 | Shared interrupt, or lower-half interrupt in split mode |
| irq_hi_o | output | 1 | Upper-half interrupt in split mode, low otherwise |

## Verification
The bench builds the unit with its default 32 pins and 4-bit address. This gives four trigger words and a 16/16 split, so both halves of the split mode and both ends of each trigger word can be reached. Random rounds draw any 4-bit code, including the illegal ones, together with random pin vectors, polarity, masks, mode and clear patterns. Directed cases cover the exact synchronizer latency and a clear write that lands in the same cycle as an edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int CODE_W = 4;
  localparam int PINS_PER_WORD = 8;

  localparam logic [CODE_W-1:0] TRG_RISE = 4'd1;
  localparam logic [CODE_W-1:0] TRG_FALL = 4'd2;
  localparam logic [CODE_W-1:0] TRG_BOTH = 4'd3;
  localparam logic [CODE_W-1:0] TRG_HIGH = 4'd4;
  localparam logic [CODE_W-1:0] TRG_LOW  = 4'd8;

  localparam int ADDR_MASK      = 0;
  localparam int ADDR_POL       = 1;
  localparam int ADDR_CLR       = 2;
  localparam int ADDR_CTRL      = 3;
  localparam int ADDR_TRIG_BASE = 8;

  typedef struct packed {
    logic rise;
    logic fall;
    logic high;
    logic low;
  } trig_sel_t;

  // Map a trigger code onto the conditions it enables; illegal codes give none.
  function automatic trig_sel_t trig_decode(input logic [CODE_W-1:0] code);
    trig_sel_t s;
    s = '0;
    case (code)
      TRG_RISE: s.rise = 1'b1;
      TRG_FALL: s.fall = 1'b1;
      TRG_BOTH: begin s.rise = 1'b1; s.fall = 1'b1; end
      TRG_HIGH: s.high = 1'b1;
      TRG_LOW:  s.low  = 1'b1;
      default:  s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [NPINS-1:0]        mask_q,
  output logic [NPINS-1:0]        pol_q,
  output logic                    split_q,
  output logic [NPINS*CODE_W-1:0] codes_q,
  output logic [NPINS-1:0]        clr_vec
);
  localparam int NWORDS = NPINS / PINS_PER_WORD;
  localparam int WORD_BITS = PINS_PER_WORD * CODE_W;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int target);
    return a == ADDR_W'(target);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '1;
      pol_q   <= '0;
      split_q <= 1'b0;
    end else if (wr_en) begin
      if (hit(wr_addr, ADDR_MASK)) mask_q  <= wr_data[NPINS-1:0];
      if (hit(wr_addr, ADDR_POL))  pol_q   <= wr_data[NPINS-1:0];
      if (hit(wr_addr, ADDR_CTRL)) split_q <= wr_data[0];
    end
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        codes_q[w*WORD_BITS +: WORD_BITS] <= '0;
      else if (wr_en && hit(wr_addr, ADDR_TRIG_BASE + w))
        codes_q[w*WORD_BITS +: WORD_BITS] <= wr_data[WORD_BITS-1:0];
    end
  end

  assign clr_vec = (wr_en && hit(wr_addr, ADDR_CLR)) ? wr_data[NPINS-1:0] : '0;
endmodule

// File: rtl/gpio_trig_cell.sv
module gpio_trig_cell
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              v_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              clr_i,
  output logic              edge_evt_o,
  output logic              sticky_o,
  output logic              pend_o
);
  trig_sel_t sel;
  logic      prev_q;
  logic      sticky_q;
  logic      level_act;

  assign sel        = trig_decode(code_i);
  assign edge_evt_o = (sel.rise & v_i & ~prev_q) | (sel.fall & ~v_i & prev_q);
  assign level_act  = (sel.high & v_i) | (sel.low & ~v_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      prev_q   <= v_i;
      sticky_q <= edge_evt_o | (sticky_q & ~clr_i);
    end
  end

  assign sticky_o = sticky_q;
  assign pend_o   = sticky_q | level_act;
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0] pend_i,
  input  logic [NPINS-1:0] mask_i,
  input  logic             split_i,
  output logic             irq_lo_o,
  output logic             irq_hi_o
);
  localparam int HALF = NPINS / 2;
  logic [NPINS-1:0] active;

  assign active   = pend_i & ~mask_i;
  assign irq_hi_o = split_i & (|active[NPINS-1:HALF]);
  assign irq_lo_o = split_i ? (|active[HALF-1:0]) : (|active);
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  pins_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NPINS-1:0]  pend_o,
  output logic              irq_lo_o,
  output logic              irq_hi_o
);
  logic [NPINS-1:0]        sync_v;
  logic [NPINS-1:0]        eval_v;
  logic [NPINS-1:0]        mask_q;
  logic [NPINS-1:0]        pol_q;
  logic                    split_q;
  logic [NPINS*CODE_W-1:0] codes_q;
  logic [NPINS-1:0]        clr_vec;
  logic [NPINS-1:0]        edge_evt;
  logic [NPINS-1:0]        sticky;

  gpio_in_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst(rst), .d_i(pins_i), .q_o(sync_v)
  );

  gpio_irq_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mask_q(mask_q), .pol_q(pol_q), .split_q(split_q), .codes_q(codes_q),
    .clr_vec(clr_vec)
  );

  assign eval_v = sync_v ^ pol_q;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    gpio_trig_cell u_cell (
      .clk(clk), .rst(rst), .v_i(eval_v[p]),
      .code_i(codes_q[p*CODE_W +: CODE_W]), .clr_i(clr_vec[p]),
      .edge_evt_o(edge_evt[p]), .sticky_o(sticky[p]), .pend_o(pend_o[p])
    );
  end

  gpio_irq_merge #(.NPINS(NPINS)) u_merge (
    .pend_i(pend_o), .mask_i(mask_q), .split_i(split_q),
    .irq_lo_o(irq_lo_o), .irq_hi_o(irq_hi_o)
  );
endmodule

// File: rtl/gpio_irq_unit_chk.sv
module gpio_irq_unit_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [NPINS-1:0] pend_o,
  input logic             irq_lo_o,
  input logic             irq_hi_o,
  input logic [NPINS-1:0] mask_q,
  input logic             split_q,
  input logic [NPINS-1:0] sticky,
  input logic [NPINS-1:0] edge_evt,
  input logic [NPINS-1:0] clr_vec
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (pend_o == '0 && !irq_lo_o && !irq_hi_o));

  p_clear_only_r8: assert property (@(posedge clk) disable iff (rst)
    (($past(sticky) & ~$past(clr_vec) & ~sticky) == '0));

  p_set_by_event_r13: assert property (@(posedge clk) disable iff (rst)
    ((sticky & ~$past(sticky) & ~$past(edge_evt)) == '0));

  p_mask_gate_r10: assert property (@(posedge clk) disable iff (rst)
    (irq_lo_o || irq_hi_o) |-> ((pend_o & ~mask_q) != '0));

  p_shared_hi_low_r11: assert property (@(posedge clk) disable iff (rst)
    !split_q |-> !irq_hi_o);
endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst(rst), .pend_o(pend_o), .irq_lo_o(irq_lo_o),
  .irq_hi_o(irq_hi_o), .mask_q(mask_q), .split_q(split_q),
  .sticky(sticky), .edge_evt(edge_evt), .clr_vec(clr_vec)
);

// File: tb/gpio_irq_unit_bench.sv
module gpio_irq_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pins = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] pend;
  logic        irq_lo;
  logic        irq_hi;

  int n_chk = 0;
  int n_err = 0;

  // bench-side model state
  logic [3:0]  m_code [32];
  logic [31:0] m_pol = '0, m_mask = '1, m_pins = '0, m_pv = '0, m_sticky = '0;
  logic        m_split = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_unit u_gpio_irq_unit (
    .clk(clk), .rst(rst), .pins_i(pins), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pend_o(pend), .irq_lo_o(irq_lo), .irq_hi_o(irq_hi)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] kinds(input logic [3:0] c);
    // {rise, fall, high, low}
    if (c == 4'd1) return 4'b1000;
    if (c == 4'd2) return 4'b0100;
    if (c == 4'd3) return 4'b1100;
    if (c == 4'd4) return 4'b0010;
    if (c == 4'd8) return 4'b0001;
    return 4'b0000;
  endfunction

  function automatic logic [31:0] exp_pend();
    logic [31:0] r;
    r = m_sticky;
    for (int p = 0; p < 32; p++) begin
      logic [3:0] k;
      k = kinds(m_code[p]);
      if ((k[1] && m_pv[p]) || (k[0] && !m_pv[p])) r[p] = 1'b1;
    end
    return r;
  endfunction

  task automatic model_step();
    logic [31:0] nv;
    nv = m_pins ^ m_pol;
    for (int p = 0; p < 32; p++) begin
      logic [3:0] k;
      k = kinds(m_code[p]);
      if ((k[3] && nv[p] && !m_pv[p]) || (k[2] && !nv[p] && m_pv[p])) m_sticky[p] = 1'b1;
    end
    m_pv = nv;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_word(input int w);
    logic [31:0] d;
    for (int k = 0; k < 8; k++) d[4*k +: 4] = m_code[w*8+k];
    wr(4'(8 + w), d);
  endtask

  task automatic set_code(input int pin, input logic [3:0] c);
    m_code[pin] = c;
    wr_word(pin / 8);
  endtask

  task automatic drive(input logic [31:0] v);
    @(negedge clk);
    pins = v; m_pins = v;
    repeat (3) @(negedge clk);
    model_step();
  endtask

  task automatic set_pol(input logic [31:0] v);
    wr(4'd1, v);
    m_pol = v;
    repeat (3) @(negedge clk);
    model_step();
  endtask

  task automatic do_clear(input logic [31:0] d);
    wr(4'd2, d);
    m_sticky &= ~d;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] ep, act;
    logic elo, ehi;
    ep  = exp_pend();
    act = ep & ~m_mask;
    elo = m_split ? |act[15:0] : |act;
    ehi = m_split & |act[31:16];
    chk({tag, " pend"}, pend, ep);
    chk({tag, " irq_lo"}, {31'b0, irq_lo}, {31'b0, elo});
    chk({tag, " irq_hi"}, {31'b0, irq_hi}, {31'b0, ehi});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240613));
    for (int p = 0; p < 32; p++) m_code[p] = 4'd0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check_all("R1 reset");
    set_code(0, 4'd4);
    drive(32'h0000_0001);
    check_all("R1 mask all set after reset, R5");
    chk("R1 masked level pin keeps irq low", {31'b0, irq_lo}, 32'd0);
    drive(32'h0);
    check_all("R5 level drop");

    // R13 latency, pin 5 rising edge, pin 6 high level
    set_code(5, 4'd1); set_code(6, 4'd4);
    @(negedge clk); pins = 32'h0000_0060; m_pins = pins;
    @(negedge clk); chk("R13 after first edge", pend & 32'h60, 32'h0);
    @(negedge clk); chk("R13 level after second edge", pend & 32'h60, 32'h40);
    @(negedge clk); chk("R13 edge after third edge", pend & 32'h60, 32'h60);
    model_step();
    drive(32'h0);
    check_all("R2 rise sticky after input low");

    // R3, R4, R6, R7
    set_code(7, 4'd2); set_code(8, 4'd3); set_code(9, 4'd5); set_code(10, 4'd8);
    set_code(11, 4'd0); set_code(31, 4'd15); set_code(24, 4'd2);
    drive(32'h8100_0F80);
    check_all("R4 R6 R7 rise pattern");
    drive(32'h0000_0000);
    check_all("R3 R4 R6 fall pattern");
    chk("R7 illegal codes quiet", pend & 32'h8000_0A00, 32'h0);
    chk("R3 pin 7 sticky", {31'b0, pend[7]}, 32'd1);
    chk("R12 pin 24 in upper word", {31'b0, pend[24]}, 32'd1);

    // R8: selective clear, then clear coinciding with edge
    do_clear(32'h0000_0020);
    check_all("R8 selective clear");
    drive(32'h0000_0100);
    check_all("R4 both pending");
    @(negedge clk); pins = 32'h0; m_pins = pins;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; wr_addr = 4'd2; wr_data = 32'h0000_0100;
    @(negedge clk); wr_en = 1'b0;
    m_sticky &= ~32'h0000_0100;
    model_step();
    chk("R8 set wins over clear", {31'b0, pend[8]}, 32'd1);
    do_clear(32'hFFFF_FFFF);
    check_all("R8 full clear");

    // R9 polarity
    set_code(12, 4'd1);
    set_pol(32'h0000_1000);
    check_all("R9 polarity flip is an edge");
    do_clear(32'hFFFF_FFFF);
    drive(32'h0000_1000);
    check_all("R9 inverted rise ignored");
    drive(32'h0);
    check_all("R9 inverted fall seen");

    // R10, R11
    wr(4'd0, 32'h0000_0000); m_mask = '0;
    check_all("R10 unmasked shared");
    wr(4'd3, 32'h1); m_split = 1'b1;
    check_all("R11 split lower");
    do_clear(32'hFFFF_FFFF);
    drive(32'h0);
    drive(32'h0100_0000);
    check_all("R11 split upper only");
    wr(4'd0, 32'hFF00_0000); m_mask = 32'hFF00_0000;
    check_all("R10 masked pending kept");
    wr(4'd3, 32'h0); m_split = 1'b0;
    wr(4'd0, 32'h0); m_mask = '0;
    check_all("R11 shared mode");

    // random rounds
    for (int it = 0; it < 150; it++) begin
      int sel;
      sel = $urandom_range(0, 9);
      if (sel < 3) begin
        int w;
        w = $urandom_range(0, 3);
        for (int k = 0; k < 8; k++) m_code[w*8+k] = 4'($urandom_range(0, 15));
        wr_word(w);
      end else if (sel == 3) begin
        set_pol($urandom);
      end else if (sel == 4) begin
        m_mask = $urandom; wr(4'd0, m_mask);
      end else if (sel == 5) begin
        m_split = 1'($urandom_range(0, 1)); wr(4'd3, {31'b0, m_split});
      end else if (sel == 6) begin
        do_clear($urandom);
      end
      drive($urandom);
      check_all("R2 R3 R4 R5 R6 R7 R12 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule